// File: doc/BRIEF.md
# Integer Execute Unit with Compares

This block is the integer execute stage of a 32-bit RISC core. Each cycle it may accept one operation. The operation comes with two register operands, an immediate that the decoder has already extended, a format flag and an operation code. The flag chooses the register form or the immediate form. One clock edge later the unit presents the result, a write-enable for the destination register, and two fault flags: divide-by-zero and illegal operation.

The unit covers add, subtract, the bitwise family, the high-half immediate logic ops, and set-on-compare in signed and unsigned forms. It also covers left shifts, arithmetic and logical right shifts, the low-half multiply, unsigned divide and modulo, and byte and halfword sign extension. Four enable inputs switch the multiplier, divider, shifter and sign extender on or off. A disabled unit turns its operations into illegal operations. When the shifter is off, one exception remains: a right shift whose amount is exactly one stays legal.

The register file, memory access and the pipeline around this stage belong to the surrounding core.

Top module: `exu_core`

## Requirements
- R1: Operation codes are ADD=0, SUB=1, AND=2, OR=3, XOR=4, NOR=5, XNOR=6, ANDHI=7, ORHI=8, CEQ=9, CNE=10, CGT=11, CGE=12, CGTU=13, CGEU=14, SL=15, SR=16, SRU=17, MUL=18, DIVU=19, MODU=20, SEXTB=21, SEXTH=22.
- R1: The second operand is `opb` when `use_imm`=0 and `imm` when `use_imm`=1. ADD and SUB wrap modulo 2^32.
- R2: AND, OR, XOR, NOR and XNOR are bitwise operations on `opa` and the second operand. XNOR gives NOT(a XOR b), so with a zero-extended immediate it gives NOT(a XOR imm16).
- R3: ANDHI gives `opa` AND (imm[15:0] shifted left by 16), which clears the low half of the result. ORHI gives `opa` OR (imm[15:0] shifted left by 16). Both ignore `use_imm`.
- R4: Each compare writes 1 when its condition holds and 0 otherwise. The conditions are equal, not-equal, signed greater, signed greater-or-equal, unsigned greater and unsigned greater-or-equal.
- R5: The shift amount is bits [4:0] of the second operand. SL fills with zeros from the right. SR fills with copies of bit 31. SRU fills with zeros from the left.
- R6: With `en_shift`=0, SL is illegal. SR and SRU are illegal unless the shift amount is exactly 1, in which case they give the normal result.
- R7: MUL gives the low 32 bits of the product. With `en_mul`=0 it is illegal.
- R8: DIVU gives the unsigned quotient and MODU the unsigned remainder. A zero second operand raises `fault_div0` and does not write. With `en_div`=0 both operations are illegal, and `fault_div0` stays 0.
- R9: SEXTB sign-extends bits [7:0] of `opa` and SEXTH sign-extends bits [15:0]. With `en_sext`=0 both are illegal.
- R10: Codes 23 to 31 are illegal. `fault_illegal` and `fault_div0` are never both 1. Either fault forces `res_we`=0 and `res_out`=0.
- R11: Outputs register one clock after an accepted operation (`issue_valid`=1). A cycle without an accepted operation and the reset state give `res_we`=0, `res_out`=0 and both faults 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| issue_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 5 | Operation code |
| use_imm | input | 1 | 1 selects the immediate as second operand |
| opa | input | 32 | First operand |
| opb | input | 32 | Second register operand |
| imm | input | 32 | Pre-extended immediate |
| en_mul | input | 1 | Multiplier present |
| en_div | input | 1 | Divider present |
| en_shift | input | 1 | Full shifter present |
| en_sext | input | 1 | Sign extender present |
| res_out | output | 32 | Registered result |
| res_we | output | 1 | Destination write enable |
| fault_div0 | output | 1 | Divide or modulo by zero |
| fault_illegal | output | 1 | Illegal or disabled operation |

## Verification
The assertions assume that the enable inputs and operands stay stable during the cycle in which `issue_valid` is high. They also assume that the immediate arrives already extended, because the unit only passes it through. The stimulus satisfies both: each operation is driven on a falling edge, with its enables, and held through the next rising edge. The vector table supplies immediates that were extended by hand, so the unit never sees a raw field.

// File: rtl/exu_pkg.sv
package exu_pkg;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_SUB   = 5'd1,
    OP_AND   = 5'd2,
    OP_OR    = 5'd3,
    OP_XOR   = 5'd4,
    OP_NOR   = 5'd5,
    OP_XNOR  = 5'd6,
    OP_ANDHI = 5'd7,
    OP_ORHI  = 5'd8,
    OP_CEQ   = 5'd9,
    OP_CNE   = 5'd10,
    OP_CGT   = 5'd11,
    OP_CGE   = 5'd12,
    OP_CGTU  = 5'd13,
    OP_CGEU  = 5'd14,
    OP_SL    = 5'd15,
    OP_SR    = 5'd16,
    OP_SRU   = 5'd17,
    OP_MUL   = 5'd18,
    OP_DIVU  = 5'd19,
    OP_MODU  = 5'd20,
    OP_SEXTB = 5'd21,
    OP_SEXTH = 5'd22
  } exu_op_e;

  function automatic logic is_cmp(exu_op_e op);
    return op inside {OP_CEQ, OP_CNE, OP_CGT, OP_CGE, OP_CGTU, OP_CGEU};
  endfunction

  function automatic logic is_shift(exu_op_e op);
    return op inside {OP_SL, OP_SR, OP_SRU};
  endfunction

  function automatic logic is_muldiv(exu_op_e op);
    return op inside {OP_MUL, OP_DIVU, OP_MODU};
  endfunction

  function automatic logic is_sext(exu_op_e op);
    return op inside {OP_SEXTB, OP_SEXTH};
  endfunction

endpackage

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int W = 32
) (
  input  exu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [W/2-1:0] imm_lo,
  output logic [W-1:0]   val,
  output logic           hit
);
  localparam int HW = W / 2;

  function automatic logic cmp_fn(exu_op_e c, logic [W-1:0] x, logic [W-1:0] y);
    case (c)
      OP_CEQ:  return x == y;
      OP_CNE:  return x != y;
      OP_CGT:  return $signed(x) >  $signed(y);
      OP_CGE:  return $signed(x) >= $signed(y);
      OP_CGTU: return x >  y;
      OP_CGEU: return x >= y;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [W-1:0] sext_fn(logic [W-1:0] x, logic half);
    if (half) return {{(W-16){x[15]}}, x[15:0]};
    return {{(W-8){x[7]}}, x[7:0]};
  endfunction

  logic [W-1:0] hi_imm;
  assign hi_imm = {imm_lo, {HW{1'b0}}};

  always_comb begin
    hit = 1'b1;
    val = '0;
    case (op)
      OP_ADD:   val = a + b;
      OP_SUB:   val = a - b;
      OP_AND:   val = a & b;
      OP_OR:    val = a | b;
      OP_XOR:   val = a ^ b;
      OP_NOR:   val = ~(a | b);
      OP_XNOR:  val = ~(a ^ b);
      OP_ANDHI: val = a & hi_imm;
      OP_ORHI:  val = a | hi_imm;
      OP_SEXTB: val = sext_fn(a, 1'b0);
      OP_SEXTH: val = sext_fn(a, 1'b1);
      default: begin
        if (is_cmp(op)) val = {{(W-1){1'b0}}, cmp_fn(op, a, b)};
        else            hit = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/exu_shift.sv
module exu_shift #(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   a,
  input  logic [SHW-1:0] amt,
  input  logic           left,
  input  logic           arith,
  input  logic           full_en,
  output logic [W-1:0]   val,
  output logic           bad
);
  logic [W-1:0] src;
  logic [W-1:0] stg [0:SHW];
  logic         fill;

  assign fill = arith & ~left & a[W-1];

  // A left shift runs through the right-shift barrel on bit-reversed data.
  for (genvar i = 0; i < W; i++) begin : g_rev_in
    assign src[i] = left ? a[W-1-i] : a[i];
  end

  assign stg[0] = src;
  for (genvar g = 0; g < SHW; g++) begin : g_stage
    assign stg[g+1] = amt[g] ? {{(1 << g){fill}}, stg[g][W-1:(1 << g)]} : stg[g];
  end

  for (genvar i = 0; i < W; i++) begin : g_rev_out
    assign val[i] = left ? stg[SHW][W-1-i] : stg[SHW][i];
  end

  // Without the full shifter, only a right shift by exactly one is legal.
  assign bad = ~full_en & (left | (amt != SHW'(1)));
endmodule

// File: rtl/exu_muldiv.sv
module exu_muldiv #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel_mul,
  input  logic         sel_div,
  input  logic         sel_mod,
  input  logic         en_mul,
  input  logic         en_div,
  output logic [W-1:0] val,
  output logic         bad,
  output logic         zero_div
);
  logic [W-1:0] prod, quo, rem;
  logic         b_zero;

  assign b_zero = (b == '0);
  assign prod   = a * b;
  assign quo    = b_zero ? '0 : a / b;
  assign rem    = b_zero ? '0 : a % b;

  assign val      = sel_mul ? prod : (sel_div ? quo : rem);
  assign bad      = (sel_mul & ~en_mul) | ((sel_div | sel_mod) & ~en_div);
  assign zero_div = (sel_div | sel_mod) & en_div & b_zero;
endmodule

// File: rtl/exu_core.sv
module exu_core
  import exu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue_valid,
  input  logic [4:0]   op_code,
  input  logic         use_imm,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] imm,
  input  logic         en_mul,
  input  logic         en_div,
  input  logic         en_shift,
  input  logic         en_sext,
  output logic [W-1:0] res_out,
  output logic         res_we,
  output logic         fault_div0,
  output logic         fault_illegal
);
  localparam int SHW = $clog2(W);

  exu_op_e      op;
  logic [W-1:0] opnd_b;
  logic [W-1:0] alu_val, shf_val, md_val, val_n;
  logic         alu_hit, shf_bad, md_bad, md_zero;
  logic         sel_shift, sel_md, sel_sx, undef_op;
  logic         ev_illegal, ev_div0, ev_write;

  assign op     = exu_op_e'(op_code);
  assign opnd_b = use_imm ? imm : opb;

  exu_alu #(.W(W)) u_alu (
    .op     (op),
    .a      (opa),
    .b      (opnd_b),
    .imm_lo (imm[W/2-1:0]),
    .val    (alu_val),
    .hit    (alu_hit)
  );

  exu_shift #(.W(W)) u_shift (
    .a       (opa),
    .amt     (opnd_b[SHW-1:0]),
    .left    (op == OP_SL),
    .arith   (op == OP_SR),
    .full_en (en_shift),
    .val     (shf_val),
    .bad     (shf_bad)
  );

  exu_muldiv #(.W(W)) u_muldiv (
    .a        (opa),
    .b        (opnd_b),
    .sel_mul  (op == OP_MUL),
    .sel_div  (op == OP_DIVU),
    .sel_mod  (op == OP_MODU),
    .en_mul   (en_mul),
    .en_div   (en_div),
    .val      (md_val),
    .bad      (md_bad),
    .zero_div (md_zero)
  );

  assign sel_shift = is_shift(op);
  assign sel_md    = is_muldiv(op);
  assign sel_sx    = is_sext(op);
  assign undef_op  = ~(alu_hit | sel_shift | sel_md);

  // Named events for the checks below.
  assign ev_illegal = undef_op | (sel_shift & shf_bad) | (sel_md & md_bad) | (sel_sx & ~en_sext);
  assign ev_div0    = ~ev_illegal & md_zero;
  assign ev_write   = issue_valid & ~ev_illegal & ~ev_div0;

  assign val_n = sel_shift ? shf_val : (sel_md ? md_val : alu_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_out       <= '0;
      res_we        <= 1'b0;
      fault_div0    <= 1'b0;
      fault_illegal <= 1'b0;
    end else begin
      res_out       <= ev_write ? val_n : '0;
      res_we        <= ev_write;
      fault_div0    <= issue_valid & ev_div0;
      fault_illegal <= issue_valid & ev_illegal;
    end
  end

  // R10: the two faults exclude each other
  p_fault_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_div0 && fault_illegal));

  // R10: a fault suppresses the write and the value
  p_fault_nowr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_div0 || fault_illegal) |-> (!res_we && res_out == '0));

  // R11: no accepted operation, no output activity
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> (!res_we && !fault_div0 && !fault_illegal));

  // R8: zero divisor on an enabled divider raises the fault
  p_div0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && (op == OP_DIVU || op == OP_MODU) && en_div && opnd_b == '0)
      |=> (fault_div0 && !res_we));

  // R6: left shift without the shifter is illegal
  p_sl_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && op == OP_SL && !en_shift) |=> fault_illegal);

  // R7: multiply without the multiplier is illegal
  p_mul_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && op == OP_MUL && !en_mul) |=> fault_illegal);

  // R4: a compare always writes a single-bit truth value
  p_cmp_bool_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && is_cmp(op)) |=> (res_we && res_out[W-1:1] == '0));
endmodule

// File: tb/exu_core_tb_top.sv
module exu_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [4:0]  op_code = '0;
  logic        use_imm = 1'b0;
  logic [31:0] opa = '0, opb = '0, imm = '0;
  logic        en_mul = 1'b1, en_div = 1'b1, en_shift = 1'b1, en_sext = 1'b1;
  logic [31:0] res_out;
  logic        res_we, fault_div0, fault_illegal;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  exu_core dut_i (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .op_code(op_code),
    .use_imm(use_imm), .opa(opa), .opb(opb), .imm(imm),
    .en_mul(en_mul), .en_div(en_div), .en_shift(en_shift), .en_sext(en_sext),
    .res_out(res_out), .res_we(res_we), .fault_div0(fault_div0),
    .fault_illegal(fault_illegal)
  );

  // feat = {mul, div, shift, sext}
  typedef struct packed {
    logic [4:0]  op;
    logic        im_f;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] im;
    logic [3:0]  feat;
    logic [31:0] er;
    logic        ewe;
    logic        ed0;
    logic        eill;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VT [NV] = '{
    // R1 add, sub, wrap, immediate select
    '{5'd0,  1'b0, 32'h7,        32'h5,        32'h0,        4'hF, 32'hC,        1'b1, 1'b0, 1'b0, 8'd1},
    '{5'd0,  1'b1, 32'hA,        32'h5,        32'hFFFFFFFF, 4'hF, 32'h9,        1'b1, 1'b0, 1'b0, 8'd1},
    '{5'd1,  1'b0, 32'h3,        32'h5,        32'h0,        4'hF, 32'hFFFFFFFE, 1'b1, 1'b0, 1'b0, 8'd1},
    '{5'd0,  1'b0, 32'hFFFFFFFF, 32'h1,        32'h0,        4'hF, 32'h0,        1'b1, 1'b0, 1'b0, 8'd1},
    // R2 logic family
    '{5'd2,  1'b0, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0,        4'hF, 32'hF000F000, 1'b1, 1'b0, 1'b0, 8'd2},
    '{5'd3,  1'b0, 32'h0F0F0000, 32'h000000FF, 32'h0,        4'hF, 32'h0F0F00FF, 1'b1, 1'b0, 1'b0, 8'd2},
    '{5'd4,  1'b0, 32'h12345678, 32'hFFFF0000, 32'h0,        4'hF, 32'hEDCB5678, 1'b1, 1'b0, 1'b0, 8'd2},
    '{5'd5,  1'b0, 32'h0F0F0F0F, 32'hF0F00000, 32'h0,        4'hF, 32'h0000F0F0, 1'b1, 1'b0, 1'b0, 8'd2},
    '{5'd6,  1'b1, 32'h0000FFFF, 32'h0,        32'h0000FF00, 4'hF, 32'hFFFFFF00, 1'b1, 1'b0, 1'b0, 8'd2},
    // R3 high-half ops, register flag ignored
    '{5'd7,  1'b0, 32'h12345678, 32'hFFFFFFFF, 32'h0000ABCD, 4'hF, 32'h02040000, 1'b1, 1'b0, 1'b0, 8'd3},
    '{5'd8,  1'b1, 32'h00001111, 32'h0,        32'h00005555, 4'hF, 32'h55551111, 1'b1, 1'b0, 1'b0, 8'd3},
    // R4 compares
    '{5'd9,  1'b0, 32'h5,        32'h5,        32'h0,        4'hF, 32'h1,        1'b1, 1'b0, 1'b0, 8'd4},
    '{5'd10, 1'b0, 32'h5,        32'h5,        32'h0,        4'hF, 32'h0,        1'b1, 1'b0, 1'b0, 8'd4},
    '{5'd11, 1'b0, 32'h1,        32'hFFFFFFFF, 32'h0,        4'hF, 32'h1,        1'b1, 1'b0, 1'b0, 8'd4},
    '{5'd13, 1'b0, 32'h1,        32'hFFFFFFFF, 32'h0,        4'hF, 32'h0,        1'b1, 1'b0, 1'b0, 8'd4},
    '{5'd12, 1'b0, 32'h80000000, 32'h80000000, 32'h0,        4'hF, 32'h1,        1'b1, 1'b0, 1'b0, 8'd4},
    '{5'd12, 1'b1, 32'hFFFFFFFE, 32'h0,        32'hFFFFFFFF, 4'hF, 32'h0,        1'b1, 1'b0, 1'b0, 8'd4},
    '{5'd14, 1'b0, 32'h0,        32'h1,        32'h0,        4'hF, 32'h0,        1'b1, 1'b0, 1'b0, 8'd4},
    // R5 shifts
    '{5'd15, 1'b0, 32'h1,        32'h24,       32'h0,        4'hF, 32'h10,       1'b1, 1'b0, 1'b0, 8'd5},
    '{5'd16, 1'b1, 32'h80000000, 32'h0,        32'h4,        4'hF, 32'hF8000000, 1'b1, 1'b0, 1'b0, 8'd5},
    '{5'd17, 1'b0, 32'h80000000, 32'h1F,       32'h0,        4'hF, 32'h1,        1'b1, 1'b0, 1'b0, 8'd5},
    // R6 shifter disabled
    '{5'd15, 1'b0, 32'h1,        32'h1,        32'h0,        4'hD, 32'h0,        1'b0, 1'b0, 1'b1, 8'd6},
    '{5'd16, 1'b1, 32'hFFFFFFF0, 32'h0,        32'h1,        4'hD, 32'hFFFFFFF8, 1'b1, 1'b0, 1'b0, 8'd6},
    '{5'd17, 1'b0, 32'h8,        32'h21,       32'h0,        4'hD, 32'h4,        1'b1, 1'b0, 1'b0, 8'd6},
    '{5'd16, 1'b1, 32'h8,        32'h0,        32'h2,        4'hD, 32'h0,        1'b0, 1'b0, 1'b1, 8'd6},
    // R7 multiply
    '{5'd18, 1'b0, 32'hFFFFFFFF, 32'h3,        32'h0,        4'hF, 32'hFFFFFFFD, 1'b1, 1'b0, 1'b0, 8'd7},
    '{5'd18, 1'b0, 32'h00010000, 32'h00010000, 32'h0,        4'hF, 32'h0,        1'b1, 1'b0, 1'b0, 8'd7},
    '{5'd18, 1'b0, 32'h2,        32'h3,        32'h0,        4'h7, 32'h0,        1'b0, 1'b0, 1'b1, 8'd7},
    // R8 divide and modulo
    '{5'd19, 1'b0, 32'd100,      32'd7,        32'h0,        4'hF, 32'hE,        1'b1, 1'b0, 1'b0, 8'd8},
    '{5'd20, 1'b0, 32'd100,      32'd7,        32'h0,        4'hF, 32'h2,        1'b1, 1'b0, 1'b0, 8'd8},
    '{5'd19, 1'b0, 32'd100,      32'h0,        32'h0,        4'hF, 32'h0,        1'b0, 1'b1, 1'b0, 8'd8},
    '{5'd20, 1'b0, 32'd100,      32'h0,        32'h0,        4'hF, 32'h0,        1'b0, 1'b1, 1'b0, 8'd8},
    '{5'd19, 1'b0, 32'd100,      32'h0,        32'h0,        4'hB, 32'h0,        1'b0, 1'b0, 1'b1, 8'd8},
    // R9 sign extension
    '{5'd21, 1'b0, 32'h000000F0, 32'h0,        32'h0,        4'hF, 32'hFFFFFFF0, 1'b1, 1'b0, 1'b0, 8'd9},
    '{5'd22, 1'b0, 32'h00007FFF, 32'h0,        32'h0,        4'hF, 32'h00007FFF, 1'b1, 1'b0, 1'b0, 8'd9},
    '{5'd21, 1'b0, 32'h00000080, 32'h0,        32'h0,        4'hE, 32'h0,        1'b0, 1'b0, 1'b1, 8'd9}
  };

  task automatic check(input logic [31:0] er, input logic ewe, input logic ed0,
                       input logic eill, input logic [7:0] req);
    total++;
    if (res_out !== er || res_we !== ewe || fault_div0 !== ed0 || fault_illegal !== eill) begin
      bad++;
      $display("FAIL R%0d: res=%h we=%b d0=%b ill=%b, expected res=%h we=%b d0=%b ill=%b",
               req, res_out, res_we, fault_div0, fault_illegal, er, ewe, ed0, eill);
    end
  endtask

  task automatic issue(input logic [4:0] op, input logic im_f, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] im, input logic [3:0] feat);
    @(negedge clk);
    op_code = op; use_imm = im_f; opa = a; opb = b; imm = im;
    {en_mul, en_div, en_shift, en_sext} = feat;
    issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    check(32'h0, 1'b0, 1'b0, 1'b0, 8'd11);
    rst_n = 1'b1;
    @(negedge clk);
    check(32'h0, 1'b0, 1'b0, 1'b0, 8'd11);

    for (int i = 0; i < NV; i++) begin
      issue(VT[i].op, VT[i].im_f, VT[i].a, VT[i].b, VT[i].im, VT[i].feat);
      check(VT[i].er, VT[i].ewe, VT[i].ed0, VT[i].eill, VT[i].req);
    end

    // R10: undefined codes are illegal and write nothing
    issue(5'd23, 1'b0, 32'h1, 32'h1, 32'h0, 4'hF);
    check(32'h0, 1'b0, 1'b0, 1'b1, 8'd10);
    issue(5'd31, 1'b1, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF, 4'hF);
    check(32'h0, 1'b0, 1'b0, 1'b1, 8'd10);

    // R11: a cycle with no accepted operation clears the outputs
    issue(5'd0, 1'b0, 32'h11, 32'h22, 32'h0, 4'hF);
    check(32'h33, 1'b1, 1'b0, 1'b0, 8'd11);
    @(negedge clk);
    check(32'h0, 1'b0, 1'b0, 1'b0, 8'd11);

    // R8: a fault does not linger into the next operation
    issue(5'd19, 1'b0, 32'h9, 32'h0, 32'h0, 4'hF);
    check(32'h0, 1'b0, 1'b1, 1'b0, 8'd8);
    issue(5'd19, 1'b0, 32'h9, 32'h3, 32'h0, 4'hF);
    check(32'h3, 1'b1, 1'b0, 1'b0, 8'd8);

    // R11: reset mid-run clears a pending result
    issue(5'd3, 1'b0, 32'hAA, 32'h55, 32'h0, 4'hF);
    check(32'hFF, 1'b1, 1'b0, 1'b0, 8'd11);
    rst_n = 1'b0;
    #1;
    check(32'h0, 1'b0, 1'b0, 1'b0, 8'd11);
    @(negedge clk);
    rst_n = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule